// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single host requests into one asynchronous bus cycle on an 8-bit NAND flash device. A request names one of four cycle kinds: a command byte, an address byte, a data write or a data read. The block then plays out three timed phases on the flash strobes. In the setup phase the bus and latch-enable lines are driven while the strobe stays idle. In the pulse phase the active-low write or read strobe is asserted. In the hold phase the bus is kept steady while the strobe is idle again. All durations come from one 32-bit timing word. Read cycles and write cycles each have their own set of four nibbles.

A host asserts `req_valid` with the cycle kind and write byte. The request is taken on the first clock edge at which the block is idle. On its last cycle the block pulses `done` for one clock, and read data is then valid on `rd_data`. When `req_wait_rdy` is set, the block adds a further delay after the hold phase before it reports `done`, so that the device's ready/busy line has time to settle. The chip-enable line is under direct host control. The ready/busy pin is synchronized and presented as a status bit.

Top module: `nand_timing_seq`

## Requirements
- R1: Timing word layout: bits [31:28] write ready delay, [27:24] write pulse, [23:20] write hold, [19:16] write setup, [15:12] read ready delay, [11:8] read pulse, [7:4] read hold, [3:0] read setup. A read (kind 2'b01) uses only the read nibbles, and every other kind uses only the write nibbles. After the accepting clock edge, the setup phase lasts n+1 clocks for a setup nibble n, with the strobes inactive.
- R2: The pulse phase directly follows setup and lasts n+1 clocks for a pulse nibble n. During it `nand_we_n` is low for write kinds (2'b00, 2'b10, 2'b11) and `nand_re_n` is low for reads. Neither strobe is low at any other time, and both are never low together.
- R3: The hold phase follows the pulse and lasts n+1 clocks for a hold nibble n. `done` is high for exactly one clock, in the cycle right after the last hold cycle (or after the last ready-delay cycle under R4).
- R4: When `req_wait_rdy` was set with the request and the selected ready-delay nibble n is non-zero, 2*n extra clocks pass between the end of hold and `done`. When the flag is clear or n is 0, no clocks are added.
- R5: Kind encoding: 2'b10 command drives `nand_cle` high, 2'b11 address drives `nand_ale` high, 2'b00 data write and 2'b01 data read drive neither. For the write kinds, `nand_dq_oe` is high and `nand_dq_out` carries the request byte from setup through pulse. A read leaves `nand_dq_oe` low.
- R6: A read captures `nand_dq_in` at the clock edge that ends the last pulse cycle. It presents that byte on `rd_data` from the `done` cycle until the next read.
- R7: While `busy` is high, `req_valid` is ignored and a changed kind or byte has no effect on the bus. A request presented in the `done` cycle is accepted, and `busy` is high in the next cycle.
- R8: `nand_ce_n` equals the inverse of `force_ce`, one clock after `force_ce` is sampled.
- R9: `ready_stat` follows `nand_rb` (1 = ready) through a two-stage synchronizer and changes on the second clock edge after a change at the pin.
- R10: A synchronous reset `rst` makes both strobes high and `nand_ce_n` high, `nand_cle`, `nand_ale`, `nand_dq_oe`, `done` and `busy` low, and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | Cycle kind: 00 write, 01 read, 10 command, 11 address |
| req_wdata | input | 8 | Byte for command, address or data write |
| req_wait_rdy | input | 1 | Append the ready-sample delay after hold |
| timing_word | input | 32 | Packed phase durations |
| force_ce | input | 1 | Hold chip enable asserted while set |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ready_stat | output | 1 | Synchronized ready/busy status, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
Two functions can fall in the same cycle: the completion pulse of one bus cycle and the acceptance of the next request. The bench provokes this by raising `req_valid` at the moment it sees `done`, and expects `busy` and the new latch-enable line in the next cycle. It also keeps `req_valid` high, with a different kind and byte, through the setup and pulse of every swept cycle. Any late acceptance then shows up as a wrong latch-enable or bus value, or as a phase count that differs from the nibble arithmetic.

// File: rtl/nts_pkg.sv
package nts_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_PULSE = 3'd2,
      PH_HOLD  = 3'd3,
      PH_WAIT  = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      K_WRITE = 2'b00,
      K_READ  = 2'b01,
      K_CMD   = 2'b10,
      K_ADDR  = 2'b11
   } kind_t;

   // nibble slot order inside one half of the timing word
   localparam int SLOT_SETUP = 0;
   localparam int SLOT_HOLD  = 1;
   localparam int SLOT_PULSE = 2;
   localparam int SLOT_RDLY  = 3;
   localparam int SLOTS_PER_DIR = 4;

endpackage

// File: rtl/nts_field_sel.sv
module nts_field_sel
   import nts_pkg::*;
#(
   parameter int FIELD_W = 4
) (
   input  logic [2*SLOTS_PER_DIR*FIELD_W-1:0] word,
   input  logic                               is_read,
   output logic [FIELD_W-1:0]                 f_setup,
   output logic [FIELD_W-1:0]                 f_pulse,
   output logic [FIELD_W-1:0]                 f_hold,
   output logic [FIELD_W-1:0]                 f_rdly
);
   localparam int NFIELDS = 2 * SLOTS_PER_DIR;

   logic [FIELD_W-1:0] fld [NFIELDS];

   genvar g;
   generate
      for (g = 0; g < NFIELDS; g++) begin : g_unpack
         assign fld[g] = word[g*FIELD_W +: FIELD_W];
      end
   endgenerate

   // read nibbles occupy the low half, write nibbles the high half
   always_comb begin
      if (is_read) begin
         f_setup = fld[SLOT_SETUP];
         f_hold  = fld[SLOT_HOLD];
         f_pulse = fld[SLOT_PULSE];
         f_rdly  = fld[SLOT_RDLY];
      end else begin
         f_setup = fld[SLOTS_PER_DIR + SLOT_SETUP];
         f_hold  = fld[SLOTS_PER_DIR + SLOT_HOLD];
         f_pulse = fld[SLOTS_PER_DIR + SLOT_PULSE];
         f_rdly  = fld[SLOTS_PER_DIR + SLOT_RDLY];
      end
   end

endmodule

// File: rtl/nts_phase_ctrl.sv
module nts_phase_ctrl
   import nts_pkg::*;
#(
   parameter int FIELD_W = 4,
   parameter int DQ_W    = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic [DQ_W-1:0]    req_wdata,
   input  logic               req_wait_rdy,
   input  logic [FIELD_W-1:0] f_setup,
   input  logic [FIELD_W-1:0] f_pulse,
   input  logic [FIELD_W-1:0] f_hold,
   input  logic [FIELD_W-1:0] f_rdly,
   input  logic [DQ_W-1:0]    dq_in,
   output phase_t             phase,
   output kind_t              kind,
   output logic [DQ_W-1:0]    wdata,
   output logic [DQ_W-1:0]    rdata,
   output logic               done,
   output logic               busy
);
   // one extra bit so twice the largest delay nibble fits
   localparam int CNT_W = FIELD_W + 1;

   phase_t             phase_q;
   kind_t              kind_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [FIELD_W-1:0] pulse_q;
   logic [FIELD_W-1:0] hold_q;
   logic [FIELD_W-1:0] rdly_q;
   logic               wait_q;
   logic [DQ_W-1:0]    wdata_q;
   logic [DQ_W-1:0]    rdata_q;
   logic               done_q;
   logic               last;

   assign last = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         kind_q  <= K_WRITE;
         cnt_q   <= '0;
         pulse_q <= '0;
         hold_q  <= '0;
         rdly_q  <= '0;
         wait_q  <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req_valid) begin
                  kind_q  <= kind_t'(req_kind);
                  wdata_q <= req_wdata;
                  wait_q  <= req_wait_rdy;
                  pulse_q <= f_pulse;
                  hold_q  <= f_hold;
                  rdly_q  <= f_rdly;
                  cnt_q   <= {1'b0, f_setup};
                  phase_q <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  cnt_q   <= {1'b0, pulse_q};
                  phase_q <= PH_PULSE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_PULSE: begin
               if (last) begin
                  if (kind_q == K_READ) begin
                     rdata_q <= dq_in;
                  end
                  cnt_q   <= {1'b0, hold_q};
                  phase_q <= PH_HOLD;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (last) begin
                  if (wait_q && (rdly_q != '0)) begin
                     cnt_q   <= {rdly_q, 1'b0} - CNT_W'(1);
                     phase_q <= PH_WAIT;
                  end else begin
                     done_q  <= 1'b1;
                     phase_q <= PH_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_WAIT: begin
               if (last) begin
                  done_q  <= 1'b1;
                  phase_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign kind  = kind_q;
   assign wdata = wdata_q;
   assign rdata = rdata_q;
   assign done  = done_q;
   assign busy  = (phase_q != PH_IDLE);

endmodule

// File: rtl/nts_bus_drive.sv
module nts_bus_drive
   import nts_pkg::*;
#(
   parameter int DQ_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  phase_t          phase,
   input  kind_t           kind,
   input  logic [DQ_W-1:0] wdata,
   input  logic            force_ce,
   output logic            ce_n,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe
);
   logic on_bus;
   logic is_rd;
   logic ce_n_q;

   // bus lines stay valid through setup, pulse and hold, not during the wait
   assign on_bus = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
   assign is_rd  = (kind == K_READ);

   assign cle    = on_bus && (kind == K_CMD);
   assign ale    = on_bus && (kind == K_ADDR);
   assign dq_oe  = on_bus && !is_rd;
   assign dq_out = dq_oe ? wdata : '0;
   assign we_n   = !((phase == PH_PULSE) && !is_rd);
   assign re_n   = !((phase == PH_PULSE) && is_rd);

   always_ff @(posedge clk) begin
      if (rst) begin
         ce_n_q <= 1'b1;
      end else begin
         ce_n_q <= !force_ce;
      end
   end

   assign ce_n = ce_n_q;

endmodule

// File: rtl/nts_rb_sync.sv
module nts_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin,
   output logic level
);
   logic [STAGES-1:0] chain_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[g] <= 1'b0;
               else     chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign level = chain_q[STAGES-1];

endmodule

// File: rtl/nand_timing_seq.sv
module nand_timing_seq
   import nts_pkg::*;
#(
   parameter int FIELD_W     = 4,
   parameter int DQ_W        = 8,
   parameter int SYNC_STAGES = 2,
   localparam int TW_W       = 2 * SLOTS_PER_DIR * FIELD_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   input  logic [1:0]      req_kind,
   input  logic [DQ_W-1:0] req_wdata,
   input  logic            req_wait_rdy,
   input  logic [TW_W-1:0] timing_word,
   input  logic            force_ce,
   output logic            busy,
   output logic            done,
   output logic [DQ_W-1:0] rd_data,
   output logic            ready_stat,
   output logic            nand_ce_n,
   output logic            nand_cle,
   output logic            nand_ale,
   output logic            nand_we_n,
   output logic            nand_re_n,
   output logic [DQ_W-1:0] nand_dq_out,
   output logic            nand_dq_oe,
   input  logic [DQ_W-1:0] nand_dq_in,
   input  logic            nand_rb
);

   generate
      if (DQ_W != 8) begin : g_bad_width
         $error("nand_timing_seq: only an 8-bit device bus is supported");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("nand_timing_seq: FIELD_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("nand_timing_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [FIELD_W-1:0] f_setup;
   logic [FIELD_W-1:0] f_pulse;
   logic [FIELD_W-1:0] f_hold;
   logic [FIELD_W-1:0] f_rdly;
   phase_t             phase;
   kind_t              kind;
   logic [DQ_W-1:0]    wdata;

   nts_field_sel #(.FIELD_W(FIELD_W)) u_fsel (
      .word    (timing_word),
      .is_read (req_kind == K_READ),
      .f_setup (f_setup),
      .f_pulse (f_pulse),
      .f_hold  (f_hold),
      .f_rdly  (f_rdly)
   );

   nts_phase_ctrl #(.FIELD_W(FIELD_W), .DQ_W(DQ_W)) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .req_valid    (req_valid),
      .req_kind     (req_kind),
      .req_wdata    (req_wdata),
      .req_wait_rdy (req_wait_rdy),
      .f_setup      (f_setup),
      .f_pulse      (f_pulse),
      .f_hold       (f_hold),
      .f_rdly       (f_rdly),
      .dq_in        (nand_dq_in),
      .phase        (phase),
      .kind         (kind),
      .wdata        (wdata),
      .rdata        (rd_data),
      .done         (done),
      .busy         (busy)
   );

   nts_bus_drive #(.DQ_W(DQ_W)) u_bus (
      .clk      (clk),
      .rst      (rst),
      .phase    (phase),
      .kind     (kind),
      .wdata    (wdata),
      .force_ce (force_ce),
      .ce_n     (nand_ce_n),
      .cle      (nand_cle),
      .ale      (nand_ale),
      .we_n     (nand_we_n),
      .re_n     (nand_re_n),
      .dq_out   (nand_dq_out),
      .dq_oe    (nand_dq_oe)
   );

   nts_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
      .clk   (clk),
      .rst   (rst),
      .pin   (nand_rb),
      .level (ready_stat)
   );

endmodule

// File: rtl/nts_checker.sv
module nts_checker #(
   parameter int DQ_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic            busy,
   input logic            done,
   input logic            force_ce,
   input logic            nand_ce_n,
   input logic            nand_cle,
   input logic            nand_ale,
   input logic            nand_we_n,
   input logic            nand_re_n,
   input logic [DQ_W-1:0] nand_dq_out
);

   // R2: the two strobes are never active together
   p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      !(!nand_we_n && !nand_re_n));

   // R2: a strobe is active only inside a bus cycle
   p_strobe_busy_r2: assert property (@(posedge clk) disable iff (rst)
      (!nand_we_n || !nand_re_n) |-> busy);

   // R3: completion lasts one clock
   p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R3: completion closes a cycle that was running
   p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(busy));

   // R5: command and address latch lines are exclusive
   p_latch_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(nand_cle && nand_ale));

   // R5: write data holds still while the write strobe stays low
   p_dq_steady_r5: assert property (@(posedge clk) disable iff (rst)
      (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

   // R8: chip enable follows the override one clock later
   p_ce_follow_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (nand_ce_n == !$past(force_ce)));

endmodule

bind nand_timing_seq nts_checker #(.DQ_W(DQ_W)) u_nts_chk (
   .clk         (clk),
   .rst         (rst),
   .busy        (busy),
   .done        (done),
   .force_ce    (force_ce),
   .nand_ce_n   (nand_ce_n),
   .nand_cle    (nand_cle),
   .nand_ale    (nand_ale),
   .nand_we_n   (nand_we_n),
   .nand_re_n   (nand_re_n),
   .nand_dq_out (nand_dq_out)
);

// File: tb/tb_nand_timing_seq.sv
`timescale 1ns/1ps
module tb_nand_timing_seq;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [7:0]  req_wdata = 8'h00;
   logic        req_wait_rdy = 1'b0;
   logic [31:0] timing_word = 32'h0;
   logic        force_ce = 1'b0;
   logic        busy, done, ready_stat;
   logic [7:0]  rd_data;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_out;
   logic [7:0]  nand_dq_in = 8'h00;
   logic        nand_rb = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nand_timing_seq dut (
      .clk          (clk),
      .rst          (rst),
      .req_valid    (req_valid),
      .req_kind     (req_kind),
      .req_wdata    (req_wdata),
      .req_wait_rdy (req_wait_rdy),
      .timing_word  (timing_word),
      .force_ce     (force_ce),
      .busy         (busy),
      .done         (done),
      .rd_data      (rd_data),
      .ready_stat   (ready_stat),
      .nand_ce_n    (nand_ce_n),
      .nand_cle     (nand_cle),
      .nand_ale     (nand_ale),
      .nand_we_n    (nand_we_n),
      .nand_re_n    (nand_re_n),
      .nand_dq_out  (nand_dq_out),
      .nand_dq_oe   (nand_dq_oe),
      .nand_dq_in   (nand_dq_in),
      .nand_rb      (nand_rb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one full bus cycle; read fields and write fields differ so a wrong half shows up
   task automatic run_cycle(input logic [1:0] k, input logic [3:0] s, input logic [3:0] p,
                            input logic [3:0] h, input logic [3:0] w, input bit wen,
                            input logic [7:0] wd, input logic [7:0] rv);
      int scount = 0;
      int pcount = 0;
      int tail = 0;
      int guard = 0;
      bit seen_low = 1'b0;
      bit seen_done = 1'b0;
      bit sig_ok = 1'b1;
      bit rd = (k == 2'b01);
      int exp_tail;
      logic strobe;
      logic [15:0] hi, lo;
      hi = {w, p, h, s};
      lo = {4'(15 - w), 4'(15 - p), 4'(15 - h), 4'(15 - s)};
      @(negedge clk);
      chk(busy == 1'b0, "R7 idle before request", int'(busy), 0);
      req_valid = 1'b1;
      req_kind = k;
      req_wdata = wd;
      req_wait_rdy = wen;
      timing_word = rd ? {lo, hi} : {hi, lo};
      nand_dq_in = ~rv;
      @(negedge clk);
      // keep requesting something else while busy: must be ignored (R7)
      req_kind = (k == 2'b10) ? 2'b11 : 2'b10;
      req_wdata = ~wd;
      req_wait_rdy = ~wen;
      while (!seen_done && guard < 200) begin
         strobe = rd ? nand_re_n : nand_we_n;
         if (done) begin
            seen_done = 1'b1;
         end else if (!seen_low && strobe) begin
            scount++;
            if (nand_cle != (k == 2'b10) || nand_ale != (k == 2'b11) ||
                nand_dq_oe != !rd || (!rd && nand_dq_out != wd) ||
                (rd ? !nand_we_n : !nand_re_n))
               sig_ok = 1'b0;
         end else if (!strobe) begin
            seen_low = 1'b1;
            pcount++;
            if (nand_cle != (k == 2'b10) || nand_ale != (k == 2'b11) ||
                nand_dq_oe != !rd || (!rd && nand_dq_out != wd))
               sig_ok = 1'b0;
            nand_dq_in = (pcount == int'(p) + 1) ? rv : ~rv;
         end else begin
            if (tail == 0) begin
               req_valid = 1'b0;
               nand_dq_in = rv ^ 8'h5A;
            end
            tail++;
         end
         guard++;
         if (!seen_done) @(negedge clk);
      end
      req_valid = 1'b0;
      exp_tail = int'(h) + 1 + ((wen && w != 0) ? 2 * int'(w) : 0);
      chk(seen_done, "R3 done reached", int'(seen_done), 1);
      chk(scount == int'(s) + 1, "R1 setup clocks", scount, int'(s) + 1);
      chk(pcount == int'(p) + 1, "R2 pulse clocks", pcount, int'(p) + 1);
      chk(tail == exp_tail, "R3/R4 hold and ready delay clocks", tail, exp_tail);
      chk(sig_ok, "R5 latch enables and bus during setup and pulse", int'(sig_ok), 1);
      if (rd) chk(rd_data == rv, "R6 read capture on last pulse clock", int'(rd_data), int'(rv));
      @(negedge clk);
      chk(done == 1'b0, "R3 done one clock", int'(done), 0);
      chk(busy == 1'b0 && nand_cle == 1'b0 && nand_ale == 1'b0, "R7 request ignored while busy",
          int'({busy, nand_cle, nand_ale}), 0);
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int vals_s[3] = '{0, 2, 15};
      int vals_p[3] = '{0, 1, 15};
      int vals_h[3] = '{0, 3, 15};
      int vals_w[4] = '{0, 1, 7, 15};
      force_ce = 1'b1;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(nand_we_n && nand_re_n && nand_ce_n, "R10 strobes and CE idle in reset",
          int'({nand_we_n, nand_re_n, nand_ce_n}), 7);
      chk(!nand_cle && !nand_ale && !nand_dq_oe && !done && !busy && rd_data == 8'h00,
          "R10 outputs low in reset", int'({nand_cle, nand_ale, nand_dq_oe, done, busy}), 0);
      rst = 1'b0;
      force_ce = 1'b0;
      @(negedge clk);

      // R8 chip enable override
      force_ce = 1'b1;
      @(negedge clk);
      chk(nand_ce_n == 1'b0, "R8 CE asserted after one clock", int'(nand_ce_n), 0);
      force_ce = 1'b0;
      @(negedge clk);
      chk(nand_ce_n == 1'b1, "R8 CE released after one clock", int'(nand_ce_n), 1);

      // R9 ready/busy synchronizer
      nand_rb = 1'b1;
      @(negedge clk);
      chk(ready_stat == 1'b0, "R9 status unchanged after one edge", int'(ready_stat), 0);
      @(negedge clk);
      chk(ready_stat == 1'b1, "R9 status ready after two edges", int'(ready_stat), 1);
      nand_rb = 1'b0;
      repeat (2) @(negedge clk);
      chk(ready_stat == 1'b0, "R9 status busy after two edges", int'(ready_stat), 0);

      // sweep phase durations over all kinds (R1, R2, R3, R5, R6)
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++)
                  run_cycle(2'(k), 4'(vals_s[a]), 4'(vals_p[b]), 4'(vals_h[c]), 4'(9),
                            1'b0, 8'(8'h11 * (a + 3 * b) + k), 8'(8'hA3 + 7 * c + 13 * k));

      // ready-sample delay, flag on and off (R4)
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 4; i++)
            for (int e = 0; e < 2; e++)
               run_cycle(2'(k), 4'(1), 4'(2), 4'(0), 4'(vals_w[i]), e[0],
                         8'(8'h30 + i), 8'(8'hC0 + i + 4 * e));

      // R7 back-to-back: request in the done cycle is taken at once
      begin
         int guard = 0;
         @(negedge clk);
         req_valid = 1'b1;
         req_kind = 2'b00;
         req_wdata = 8'h77;
         req_wait_rdy = 1'b0;
         timing_word = 32'h0000_0000;
         @(negedge clk);
         req_valid = 1'b0;
         while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
         end
         chk(done == 1'b1, "R7 first cycle completes", int'(done), 1);
         req_valid = 1'b1;
         req_kind = 2'b10;
         req_wdata = 8'h5C;
         @(negedge clk);
         req_valid = 1'b0;
         chk(busy == 1'b1, "R7 accepted in done cycle", int'(busy), 1);
         chk(nand_cle == 1'b1 && nand_dq_out == 8'h5C, "R7 new command on bus",
             int'(nand_dq_out), 'h5C);
         repeat (6) @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule